// File: doc/BRIEF.md
# Asynchronous Static RAM Timing Controller

This block sits between a synchronous user port and an external asynchronous static RAM. The RAM has a separate address bus, a bidirectional data bus, two chip selects (one active-low, one active-high), an active-low write strobe and an active-low output enable. Each user command becomes a pin sequence whose phases last a whole number of clock cycles. Every phase length is derived at elaboration from a nanosecond minimum, given in picoseconds, and the clock period, rounding up. Retargeting the block to another speed grade or clock therefore only changes parameters.

After reset the controller counts out a power-up interval before it accepts any command. A read holds both selects and the output enable for the read window, captures the bus at the end of that window, and then waits out a bus turnaround. A write stores the data on the rising edge of the write strobe, which ends the overlap of the selects and the strobe. The controller drives data on the bus only while it is writing. A parameter chooses between two write styles: output enable held high during the write, or output enable held low. With output enable low, the write pulse is stretched so that the memory first releases the bus and the data then still meets its setup time.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `req_ready` stays low and all memory controls stay inactive (`mem_sel_n`=1, `mem_sel`=0, `mem_wr_en_n`=1, `mem_out_en_n`=1). `req_ready` first reads high after rising clock edge PU+1, where PU = ceil(T_PWRUP_PS / CLK_PS).
- R2: A request is taken only in a cycle where `req_ready` is high. `req_valid` at any other time, including during power-up and during an access, starts no memory cycle.
- R3: A read keeps both selects active and `mem_out_en_n` low for RD = ceil(max(tRC, tAA, tACE, tDOE) / CLK_PS) cycles, with `mem_wr_en_n` high. In the cycle after those pins drop, `rd_valid` is high for exactly one cycle and `rd_data` holds the bus value.
- R4: After a read, `req_ready` returns only after TURN = ceil(tHZOE / CLK_PS) further cycles with the memory idle.
- R5: A write holds `mem_wr_en_n` low for WP cycles, with both selects active throughout. With OE_LOW_WR=0, WP = ceil(max(tPWE, tAW, tSCE, tSD) / CLK_PS). The memory stores the driven data on the rising edge of `mem_wr_en_n`.
- R6: A write keeps the selects active for WP+REC cycles, where REC = max(1, WC − WP) and WC is the write cycle length in cycles. `wr_ack` is high for one cycle right after that, together with `req_ready`.
- R7: With OE_LOW_WR=1, `mem_out_en_n` is low during the write pulse, and WP = max(base WP, ceil(tHZWE) + ceil(tSD)). The controller leaves the bus undriven for the first ceil(tHZWE) cycles of the pulse. With OE_LOW_WR=0, `mem_out_en_n` stays high during writes.
- R8: `mem_addr` stays constant for as long as the selects stay active.
- R9: The controller never drives `mem_dq` while `mem_out_en_n` is low and `mem_wr_en_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle and power-up complete; a command is taken this cycle |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Captured read data |
| wr_ack | output | 1 | One-cycle write completion strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_en_n | output | 1 | Active-low write strobe |
| mem_out_en_n | output | 1 | Active-low output enable |

## Verification
A phase counter that is off by one shows up as a select, strobe or output-enable window one cycle too short or too long. That error appears within the same access, and the bench measures each window sample by sample. A sequencer state that is wrong after reset shows up as `req_ready` rising at the wrong edge, or as a memory cycle starting before power-up completes. A wrong data-drive decision shows up as corrupted data on the readback that follows the write. Bus contention in the output-enable-low write style is caught by the checker in the cycle it occurs.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WPULSE,
    ST_WREC
  } seq_st_t;

  // Round a picosecond minimum up to whole clock cycles, never below one.
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
module sram_ctl_pwrup #(
  parameter int PU_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(PU_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(PU_CYC - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int WP_CYC    = 1,
  parameter int REC_CYC   = 1,
  parameter int HZ_CYC    = 1,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pu_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              sel_n,
  output logic              sel,
  output logic              wr_n,
  output logic              oe_n
);
  localparam int MAXC     = max2(max2(RD_CYC, TURN_CYC), max2(WP_CYC, REC_CYC));
  localparam int CW       = $clog2(MAXC + 1);
  localparam int DRV_FROM = WP_CYC - HZ_CYC;

  seq_st_t       st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          last;
  logic          take;
  logic          nxt_active;
  logic          nxt_drive;
  logic          nxt_oe;

  assign last      = (cnt == '0);
  assign req_ready = (st == ST_IDLE);
  assign take      = req_ready && req_valid;

  always_comb begin
    st_d  = st;
    cnt_d = last ? cnt : cnt - 1'b1;
    unique case (st)
      ST_PWRUP: if (pu_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (req_valid) begin
          st_d  = req_write ? ST_WPULSE : ST_RD;
          cnt_d = req_write ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        if (last) begin
          st_d  = ST_TURN;
          cnt_d = CW'(TURN_CYC - 1);
        end
      end
      ST_TURN:   if (last) st_d = ST_IDLE;
      ST_WPULSE: begin
        if (last) begin
          st_d  = ST_WREC;
          cnt_d = CW'(REC_CYC - 1);
        end
      end
      ST_WREC:   if (last) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign nxt_active = (st_d == ST_RD) || (st_d == ST_WPULSE) || (st_d == ST_WREC);
  assign nxt_oe     = (st_d == ST_RD) || (OE_LOW_WR && (st_d == ST_WPULSE));
  assign nxt_drive  = ((st_d == ST_WPULSE) && (!OE_LOW_WR || (cnt_d < CW'(DRV_FROM))))
                   || (st_d == ST_WREC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_PWRUP;
      cnt      <= '0;
      sel_n    <= 1'b1;
      sel      <= 1'b0;
      wr_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      addr_q   <= '0;
      dq_out   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_ack   <= 1'b0;
    end else begin
      st       <= st_d;
      cnt      <= cnt_d;
      sel_n    <= !nxt_active;
      sel      <= nxt_active;
      wr_n     <= (st_d != ST_WPULSE);
      oe_n     <= !nxt_oe;
      dq_oe    <= nxt_drive;
      rd_valid <= (st == ST_RD) && last;
      wr_ack   <= (st == ST_WREC) && last;
      if (take) begin
        addr_q <= req_addr;
        dq_out <= req_wdata;
      end
      if ((st == ST_RD) && last) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 8000,
  parameter int T_PWRUP_PS = 1000000000,
  parameter int T_RC_PS    = 10000,
  parameter int T_AA_PS    = 10000,
  parameter int T_ACE_PS   = 10000,
  parameter int T_DOE_PS   = 5000,
  parameter int T_HZOE_PS  = 5000,
  parameter int T_WC_PS    = 10000,
  parameter int T_PWE_PS   = 7000,
  parameter int T_AW_PS    = 7000,
  parameter int T_SCE_PS   = 7000,
  parameter int T_SD_PS    = 5500,
  parameter int T_HZWE_PS  = 5000,
  parameter bit OE_LOW_WR  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_en_n,
  output logic              mem_out_en_n
);
  localparam int PU_CYC   = cyc_of(T_PWRUP_PS, CLK_PS);
  localparam int RD_CYC   = cyc_of(max2(max2(T_RC_PS, T_AA_PS), max2(T_ACE_PS, T_DOE_PS)), CLK_PS);
  localparam int TURN_CYC = cyc_of(T_HZOE_PS, CLK_PS);
  localparam int HZ_CYC   = cyc_of(T_HZWE_PS, CLK_PS);
  localparam int SD_CYC   = cyc_of(T_SD_PS, CLK_PS);
  localparam int WP_BASE  = cyc_of(max2(max2(T_PWE_PS, T_AW_PS), max2(T_SCE_PS, T_SD_PS)), CLK_PS);
  localparam int WP_CYC   = OE_LOW_WR ? max2(WP_BASE, HZ_CYC + SD_CYC) : WP_BASE;
  localparam int WC_CYC   = OE_LOW_WR ? cyc_of(max2(T_WC_PS, T_HZWE_PS + T_SD_PS), CLK_PS)
                                      : cyc_of(T_WC_PS, CLK_PS);
  localparam int REC_CYC  = max2(1, WC_CYC - WP_CYC);

  logic              pu_done;
  logic              dq_oe;
  logic [DATA_W-1:0] dq_out;
  logic [DATA_W-1:0] dq_in;

  assign mem_dq = dq_oe ? dq_out : 'z;
  assign dq_in  = mem_dq;

  sram_ctl_pwrup #(.PU_CYC(PU_CYC)) u_pwrup (
    .clk  (clk),
    .rst_n(rst_n),
    .done (pu_done)
  );

  sram_ctl_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC),
    .HZ_CYC   (HZ_CYC),
    .OE_LOW_WR(OE_LOW_WR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pu_done  (pu_done),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_in    (dq_in),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .wr_ack   (wr_ack),
    .addr_q   (mem_addr),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .sel_n    (mem_sel_n),
    .sel      (mem_sel),
    .wr_n     (mem_wr_en_n),
    .oe_n     (mem_out_en_n)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W    = 18,
  parameter bit OE_LOW_WR = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sel,
  input logic              wr_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              wr_ack,
  input logic              pu_done,
  input logic              dq_oe
);
  AST_QUIET_BEFORE_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_done |-> (sel_n && !sel && wr_n && oe_n && !req_ready)); // R1
  AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sel_n && wr_n && oe_n)); // R2
  AST_RDVALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!sel_n && sel)); // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack); // R6
  AST_OE_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (oe_n == !OE_LOW_WR)); // R7
  AST_PULSE_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (dq_oe == !OE_LOW_WR)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $past(!sel_n)) |-> $stable(addr)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n && wr_n)); // R9
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .OE_LOW_WR(OE_LOW_WR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (mem_sel_n),
  .sel      (mem_sel),
  .wr_n     (mem_wr_en_n),
  .oe_n     (mem_out_en_n),
  .addr     (mem_addr),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .wr_ack   (wr_ack),
  .pu_done  (pu_done),
  .dq_oe    (dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_model #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic [AW-1:0] a,
  inout  wire  [DW-1:0] dq,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          wr_n,
  input  logic          oe_n
);
  logic [DW-1:0] mem [16];
  always @(posedge wr_n) if (!sel_n && sel) mem[a[3:0]] <= dq;
  assign dq = (!sel_n && sel && !oe_n && wr_n) ? mem[a[3:0]] : 'z;
endmodule

module tb_sram_ctl;
  // 2 us power-up at 8 ns -> 250 cycles; read 10 ns -> 2; turnaround 5 ns -> 1;
  // write pulse 7 ns -> 1, cycle 10 ns -> 2; output-enable-low pulse 5 + 5.5 ns -> 1 + 1.
  localparam int EXP_PU       = 250;
  localparam int EXP_RD       = 2;
  localparam int EXP_TURN     = 1;
  localparam int EXP_WP       = 1;
  localparam int EXP_WACT     = 2;
  localparam int EXP_WP_OEL   = 2;
  localparam int EXP_WACT_OEL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_dut = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic rdy0, rv0, ack0, sn0, s0, wn0, on0;
  logic rdy1, rv1, ack1, sn1, s1, wn1, on1;
  logic [15:0] rd0, rd1;
  logic [17:0] a0, a1;
  wire  [15:0] dq0, dq1;

  sram_ctl #(.T_PWRUP_PS(2000000)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel_dut), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy0), .rd_valid(rv0),
    .rd_data(rd0), .wr_ack(ack0), .mem_addr(a0), .mem_dq(dq0), .mem_sel_n(sn0),
    .mem_sel(s0), .mem_wr_en_n(wn0), .mem_out_en_n(on0));
  tb_sram_model m0 (.a(a0), .dq(dq0), .sel_n(sn0), .sel(s0), .wr_n(wn0), .oe_n(on0));

  sram_ctl #(.T_PWRUP_PS(2000000), .OE_LOW_WR(1'b1)) dut_oel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel_dut), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy1), .rd_valid(rv1),
    .rd_data(rd1), .wr_ack(ack1), .mem_addr(a1), .mem_dq(dq1), .mem_sel_n(sn1),
    .mem_sel(s1), .mem_wr_en_n(wn1), .mem_out_en_n(on1));
  tb_sram_model m1 (.a(a1), .dq(dq1), .sel_n(sn1), .sel(s1), .wr_n(wn1), .oe_n(on1));

  logic o_rdy, o_rv, o_ack, o_sn, o_s, o_wn, o_on;
  logic [15:0] o_rd;
  logic [17:0] o_a;
  assign o_rdy = sel_dut ? rdy1 : rdy0;
  assign o_rv  = sel_dut ? rv1  : rv0;
  assign o_ack = sel_dut ? ack1 : ack0;
  assign o_sn  = sel_dut ? sn1  : sn0;
  assign o_s   = sel_dut ? s1   : s0;
  assign o_wn  = sel_dut ? wn1  : wn0;
  assign o_on  = sel_dut ? on1  : on0;
  assign o_rd  = sel_dut ? rd1  : rd0;
  assign o_a   = sel_dut ? a1   : a0;

  int m_act, m_we, m_oe, m_oe_wr, m_rv_n, m_rv_idx, m_ack_n, m_ack_idx, m_rdy_idx, m_last, m_abad;
  logic [15:0] m_rd;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One access; samples every cycle at the falling edge until ready returns.
  task automatic run_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input bit poke);
    m_act = 0; m_we = 0; m_oe = 0; m_oe_wr = 0; m_rv_n = 0; m_rv_idx = 0;
    m_ack_n = 0; m_ack_idx = 0; m_rdy_idx = 0; m_last = 0; m_abad = 0; m_rd = '0;
    @(negedge clk);
    while (!o_rdy) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (i == 1) begin req_valid = poke; req_write = 1'b1; req_addr = ~a; end
      else if (i == 3) req_valid = 1'b0;
      if (!o_sn && o_s) begin m_act++; m_last = i; if (o_a !== a) m_abad++; end
      if (!o_wn) begin m_we++; if (!o_on) m_oe_wr++; end
      if (!o_on) m_oe++;
      if (o_rv) begin m_rv_n++; m_rv_idx = i; m_rd = o_rd; end
      if (o_ack) begin m_ack_n++; m_ack_idx = i; end
      if (o_rdy) begin m_rdy_idx = i; break; end
    end
  endtask

  task automatic test_reset_pwrup();
    int pu0 = 0, pu1 = 0, act = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(rdy0 | rdy1), 0);
    chk("R1 reset controls idle", int'({sn0, s0, wn0, on0, sn1, s1, wn1, on1}), 8'b1011_1011);
    rst_n = 1'b1;
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      if (!sn0 || !wn0 || !on0 || !sn1) act++;
      if (rdy0 && pu0 == 0) pu0 = i;
      if (rdy1 && pu1 == 0) pu1 = i;
      req_valid = (i < 200);
      req_write = i[0];
      if (pu0 != 0 && pu1 != 0) break;
    end
    req_valid = 1'b0;
    chk("R1 ready edge (default style)", pu0, EXP_PU + 1);
    chk("R1 ready edge (oe-low style)", pu1, EXP_PU + 1);
    chk("R2 no access during power-up", act, 0);
  endtask

  task automatic test_write_oe_high(input logic [17:0] a, input logic [15:0] d);
    sel_dut = 1'b0;
    run_op(1'b1, a, d, 1'b0);
    chk("R5 strobe width", m_we, EXP_WP);
    chk("R6 select window", m_act, EXP_WACT);
    chk("R6 ack count", m_ack_n, 1);
    chk("R6 ack timing", m_ack_idx, m_last + 1);
    chk("R7 oe high in write", m_oe, 0);
    chk("R8 address held", m_abad, 0);
  endtask

  task automatic test_read(input logic [17:0] a, input logic [15:0] exp, input bit poke);
    run_op(1'b0, a, 16'h0, poke);
    chk("R3 select window", m_act, EXP_RD);
    chk("R3 oe window", m_oe, EXP_RD);
    chk("R3 data", int'(m_rd), int'(exp));
    chk("R3 valid pulse", m_rv_n, 1);
    chk("R3 valid timing", m_rv_idx, m_last + 1);
    chk("R4 turnaround", m_rdy_idx - m_rv_idx, EXP_TURN);
    chk("R8 address held", m_abad, 0);
    if (poke) chk("R2 busy request ignored", m_we, 0);
  endtask

  task automatic test_write_oe_low(input logic [17:0] a, input logic [15:0] d);
    sel_dut = 1'b1;
    run_op(1'b1, a, d, 1'b0);
    chk("R7 stretched strobe", m_we, EXP_WP_OEL);
    chk("R7 oe low across strobe", m_oe_wr, EXP_WP_OEL);
    chk("R6 select window oe-low", m_act, EXP_WACT_OEL);
    chk("R6 ack timing oe-low", m_ack_idx, m_last + 1);
    // R9: readback is corrupted if the controller fights the memory on the bus
    test_read(a, d, 1'b0);
    sel_dut = 1'b0;
  endtask

  initial begin
    test_reset_pwrup();
    test_write_oe_high(18'h00003, 16'hA5C3);
    test_write_oe_high(18'h3FFFC, 16'h0F0F);
    test_read(18'h00003, 16'hA5C3, 1'b0);
    test_read(18'h3FFFC, 16'h0F0F, 1'b1);
    test_write_oe_high(18'h00003, 16'hFFFF);
    test_read(18'h00003, 16'hFFFF, 1'b0);
    test_write_oe_low(18'h00005, 16'h1234);
    test_write_oe_low(18'h0000A, 16'h0000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule